// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port: a transmitter with a one-character holding register in front of a shift register, and a receiver with a one-character result register. The character format is set by configuration inputs. Each character has 7, 8 or 9 data bits, an optional odd or even parity bit, and one or two stop bits. Every frame starts with a single low start bit, and data travels least-significant bit first.

Both directions share one baud generator. It takes one of four internal clock sources, or the rising edges of an external clock pin. It divides that clock by a programmable 8-bit value plus one, and the result is a 16x oversample tick. One bit time is therefore 16·(n+1) source clocks.

The receiver confirms a start bit at its midpoint and samples every later bit at mid-bit. It reports parity, framing and overrun errors, and an error-sum flag. One transmit interrupt line signals either that the holding register is empty or that transmission has fully completed, chosen by a configuration input. A separate line signals that a received character is waiting to be read.

Top module: `sercom_xcvr`

## Requirements
- R1: After reset, txd is high, rx_full, irq_rx and all error flags are low, and irq_tx is high.
- R2: A written character goes out as one low start bit, then the data bits LSB first, then the parity bit when enabled, then one or two high stop bits. cfg_len is 0 for 7 bits, 1 for 8 bits and 2 for 9 bits. Each bit lasts 16·(cfg_div+1) source ticks.
- R3: cfg_par is 0 for no parity, 1 for even and 2 for odd. The parity bit covers only the cfg_len data bits. With even parity, the data bits and the parity bit together hold an even number of ones; with odd parity, an odd number.
- R4: cfg_ext=0 selects the source by cfg_src: 0 for clk, 1 for clk/8, 2 for clk/32, 3 for clock cycles with aux_tick high. cfg_ext=1 selects rising edges of ext_clk. The bit time is 16·(cfg_div+1) source ticks.
- R5: A received character appears on rx_data, with bits above the data length at zero. rx_full and irq_rx stay high until rx_rd is pulsed.
- R6: err_parity is set when the received parity bit does not match the configured parity. It is cleared by the next character that is accepted.
- R7: err_frame is set when any received stop bit is low. It is cleared by the next character that is accepted.
- R8: If a character completes while rx_full is high, err_overrun is set and the new character is discarded, so rx_data keeps the old value. rx_rd clears both rx_full and err_overrun.
- R9: err_sum is high exactly when at least one of err_overrun, err_frame and err_parity is high.
- R10: With cfg_txirq_sel=0, irq_tx means the holding register is empty. With cfg_txirq_sel=1, it means the holding register is empty and the transmitter has finished its frame.
- R11: A tx_wr while the holding register is full is ignored.
- R12: A low pulse on rxd that ends before the mid-point of the start bit does not start a character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_src | input | 2 | Internal clock source select |
| cfg_ext | input | 1 | 1: bit clock from ext_clk rising edges |
| cfg_div | input | DIV_W | Divisor n; bit time is 16·(n+1) source ticks |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 2 | Parity code |
| cfg_stop2 | input | 1 | 1: two stop bits |
| cfg_txirq_sel | input | 1 | Transmit interrupt meaning select |
| aux_tick | input | 1 | Auxiliary clock enable, one source tick per high cycle |
| ext_clk | input | 1 | External clock pin (asynchronous) |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_data | input | 9 | Character to send |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_rd | input | 1 | Read acknowledge for the received character |
| rx_data | output | 9 | Received character |
| rx_full | output | 1 | Received character waiting |
| err_overrun | output | 1 | Overrun error |
| err_frame | output | 1 | Framing error |
| err_parity | output | 1 | Parity error |
| err_sum | output | 1 | OR of the three error flags |
| irq_tx | output | 1 | Transmit interrupt (level) |
| irq_rx | output | 1 | Reception-complete interrupt (level) |

## Verification
The assertions assume that the configuration inputs stay unchanged while a frame is in flight in either direction. They also assume that rxd and ext_clk may change at any clock, because each passes through a synchroniser. The stimulus therefore changes the format, divisor and source only when the transmitter reports completion and the receiver has no character in progress. Externally driven frames use the exact bit time that the divisor sets, so mid-bit sampling falls well inside each bit.

// File: rtl/sercom_pkg.sv
`timescale 1ns/1ps
package sercom_pkg;
    localparam int unsigned OS_RATE   = 16;
    localparam int unsigned DMAX      = 9;
    localparam int unsigned FRAME_MAX = 1 + DMAX + 1 + 2;

    typedef enum logic [1:0] {LEN_7 = 2'd0, LEN_8 = 2'd1, LEN_9 = 2'd2} len_e;
    typedef enum logic [1:0] {PAR_OFF = 2'd0, PAR_EVEN = 2'd1, PAR_ODD = 2'd2} par_e;
    typedef enum logic [1:0] {SRC_DIV1 = 2'd0, SRC_DIV8 = 2'd1, SRC_DIV32 = 2'd2, SRC_AUX = 2'd3} src_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

    typedef struct packed {
        len_e len;
        par_e par;
        logic stop2;
    } fmt_t;

    function automatic logic [3:0] data_bits(len_e l);
        case (l)
            LEN_7:   return 4'd7;
            LEN_9:   return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [DMAX-1:0] data_mask(len_e l);
        case (l)
            LEN_7:   return 9'h07F;
            LEN_9:   return 9'h1FF;
            default: return 9'h0FF;
        endcase
    endfunction

    function automatic logic has_par(fmt_t f);
        return (f.par == PAR_EVEN) || (f.par == PAR_ODD);
    endfunction

    function automatic logic par_bit(logic [DMAX-1:0] d, fmt_t f);
        return (^(d & data_mask(f.len))) ^ (f.par == PAR_ODD);
    endfunction
endpackage

// File: rtl/sercom_baud.sv
`timescale 1ns/1ps
module sercom_baud
    import sercom_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       src_sel,
    input  logic             ext_sel,
    input  logic             aux_en,
    input  logic             ext_pin,
    input  logic [DIV_W-1:0] div,
    output logic             os_tick
);
    localparam int PRE_W = 5;

    logic [PRE_W-1:0] pre;
    logic [2:0]       ext_s;
    logic             src_tick, ext_rise, tick_in;
    logic [DIV_W-1:0] div_cnt;

    assign ext_rise = ext_s[1] & ~ext_s[2];
    assign tick_in  = ext_sel ? ext_rise : src_tick;

    always_comb begin
        case (src_e'(src_sel))
            SRC_DIV1:  src_tick = 1'b1;
            SRC_DIV8:  src_tick = &pre[2:0];
            SRC_DIV32: src_tick = &pre;
            default:   src_tick = aux_en;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre     <= '0;
            ext_s   <= '0;
            div_cnt <= '0;
            os_tick <= 1'b0;
        end else begin
            pre     <= pre + 1'b1;
            ext_s   <= {ext_s[1:0], ext_pin};
            os_tick <= 1'b0;
            if (tick_in) begin
                if (div_cnt >= div) begin
                    div_cnt <= '0;
                    os_tick <= 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    // R4
    tick_source_chk: assert property (@(posedge clk) disable iff (rst)
        os_tick |-> $past(tick_in));
endmodule

// File: rtl/sercom_tx.sv
`timescale 1ns/1ps
module sercom_tx
    import sercom_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            os_tick,
    input  fmt_t            fmt,
    input  logic            wr,
    input  logic [DMAX-1:0] wdata,
    output logic            txd,
    output logic            hold_empty,
    output logic            line_idle
);
    localparam int CNT_W = $clog2(FRAME_MAX + 1);

    logic                 hold_full, busy, move;
    logic [DMAX-1:0]      hold_q;
    logic [FRAME_MAX-1:0] sh, frm_bits;
    logic [CNT_W-1:0]     left, frm_len;
    logic [3:0]           os_cnt;

    always_comb begin
        int nb;
        nb       = int'(data_bits(fmt.len));
        frm_bits = '1;
        frm_bits[0] = 1'b0;
        for (int i = 0; i < int'(DMAX); i++)
            if (i < nb) frm_bits[1+i] = hold_q[i];
        if (has_par(fmt)) frm_bits[1+nb] = par_bit(hold_q, fmt);
        frm_len = CNT_W'(2 + nb + int'(has_par(fmt)) + int'(fmt.stop2));
    end

    assign move       = !busy && hold_full && os_tick;
    assign txd        = busy ? sh[0] : 1'b1;
    assign hold_empty = !hold_full;
    assign line_idle  = !busy && !hold_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_q    <= '0;
            busy      <= 1'b0;
            sh        <= '1;
            left      <= '0;
            os_cnt    <= '0;
        end else begin
            if (move) begin
                busy   <= 1'b1;
                sh     <= frm_bits;
                left   <= frm_len;
                os_cnt <= '0;
            end else if (busy && os_tick) begin
                if (os_cnt == 4'(OS_RATE - 1)) begin
                    os_cnt <= '0;
                    sh     <= {1'b1, sh[FRAME_MAX-1:1]};
                    left   <= left - 1'b1;
                    if (left == CNT_W'(1)) busy <= 1'b0;
                end else begin
                    os_cnt <= os_cnt + 1'b1;
                end
            end
            if (move) begin
                hold_full <= 1'b0;
            end else if (wr && !hold_full) begin
                hold_full <= 1'b1;
                hold_q    <= wdata;
            end
        end
    end

    // R2
    frame_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(os_tick));
    // R11
    wr_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_full && wr) |=> (hold_q == $past(hold_q)));
endmodule

// File: rtl/sercom_rx.sv
`timescale 1ns/1ps
module sercom_rx
    import sercom_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            os_tick,
    input  fmt_t            fmt,
    input  logic            rxd,
    input  logic            rd,
    output logic [DMAX-1:0] rdata,
    output logic            full,
    output logic            ovr,
    output logic            frm_err,
    output logic            par_err
);
    rx_st_e          st;
    logic [1:0]      sync;
    logic            rxs, rxs_d, fall, mid, stop_idx, par_bad, stop_bad;
    logic [3:0]      os_cnt, bit_idx, nb;
    logic [DMAX-1:0] shreg;

    assign rxs  = sync[1];
    assign fall = rxs_d & ~rxs;
    assign mid  = os_tick && (os_cnt == 4'(OS_RATE - 1));
    assign nb   = data_bits(fmt.len);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync     <= 2'b11;
            rxs_d    <= 1'b1;
            st       <= RX_IDLE;
            os_cnt   <= '0;
            bit_idx  <= '0;
            stop_idx <= 1'b0;
            shreg    <= '0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
            rdata    <= '0;
            full     <= 1'b0;
            ovr      <= 1'b0;
            frm_err  <= 1'b0;
            par_err  <= 1'b0;
        end else begin
            sync  <= {sync[0], rxd};
            rxs_d <= rxs;
            if (rd) begin
                full <= 1'b0;
                ovr  <= 1'b0;
            end
            if (st != RX_IDLE && os_tick)
                os_cnt <= mid ? '0 : os_cnt + 1'b1;
            case (st)
                RX_IDLE: if (fall) begin
                    st     <= RX_START;
                    os_cnt <= '0;
                end
                RX_START: if (os_tick && os_cnt == 4'(OS_RATE/2 - 1)) begin
                    os_cnt   <= '0;
                    bit_idx  <= '0;
                    stop_idx <= 1'b0;
                    shreg    <= '0;
                    par_bad  <= 1'b0;
                    stop_bad <= 1'b0;
                    st       <= rxs ? RX_IDLE : RX_DATA;
                end
                RX_DATA: if (mid) begin
                    shreg[bit_idx] <= rxs;
                    if (bit_idx == nb - 4'd1) st <= has_par(fmt) ? RX_PAR : RX_STOP;
                    else bit_idx <= bit_idx + 1'b1;
                end
                RX_PAR: if (mid) begin
                    par_bad <= (rxs != par_bit(shreg, fmt));
                    st      <= RX_STOP;
                end
                RX_STOP: if (mid) begin
                    if (fmt.stop2 && !stop_idx) begin
                        stop_idx <= 1'b1;
                        stop_bad <= stop_bad | ~rxs;
                    end else begin
                        st <= RX_IDLE;
                        if (full && !rd) begin
                            ovr <= 1'b1;
                        end else begin
                            rdata   <= shreg;
                            full    <= 1'b1;
                            frm_err <= stop_bad | ~rxs;
                            par_err <= par_bad;
                        end
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    // R8
    ovr_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
        ovr |-> full);
    // R8
    rdata_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (full && !rd) |=> (rdata == $past(rdata)));
    // R5
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(full) |-> $past(rd));
    // R12
    start_confirm_chk: assert property (@(posedge clk) disable iff (rst)
        ((st == RX_DATA) && $past(st == RX_START)) |-> $past(!rxs));
endmodule

// File: rtl/sercom_xcvr.sv
`timescale 1ns/1ps
module sercom_xcvr
    import sercom_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [1:0]                    cfg_src,
    input  logic                          cfg_ext,
    input  logic [DIV_W-1:0]              cfg_div,
    input  logic [1:0]                    cfg_len,
    input  logic [1:0]                    cfg_par,
    input  logic                          cfg_stop2,
    input  logic                          cfg_txirq_sel,
    input  logic                          aux_tick,
    input  logic                          ext_clk,
    input  logic                          tx_wr,
    input  logic [sercom_pkg::DMAX-1:0]   tx_data,
    output logic                          txd,
    input  logic                          rxd,
    input  logic                          rx_rd,
    output logic [sercom_pkg::DMAX-1:0]   rx_data,
    output logic                          rx_full,
    output logic                          err_overrun,
    output logic                          err_frame,
    output logic                          err_parity,
    output logic                          err_sum,
    output logic                          irq_tx,
    output logic                          irq_rx
);
    fmt_t fmt;
    logic os_tick, hold_empty, line_idle;

    assign fmt = '{len: len_e'(cfg_len), par: par_e'(cfg_par), stop2: cfg_stop2};

    sercom_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst(rst), .src_sel(cfg_src), .ext_sel(cfg_ext),
        .aux_en(aux_tick), .ext_pin(ext_clk), .div(cfg_div), .os_tick(os_tick)
    );

    sercom_tx u_tx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .fmt(fmt), .wr(tx_wr),
        .wdata(tx_data), .txd(txd), .hold_empty(hold_empty), .line_idle(line_idle)
    );

    sercom_rx u_rx (
        .clk(clk), .rst(rst), .os_tick(os_tick), .fmt(fmt), .rxd(rxd), .rd(rx_rd),
        .rdata(rx_data), .full(rx_full), .ovr(err_overrun),
        .frm_err(err_frame), .par_err(err_parity)
    );

    assign err_sum = err_overrun | err_frame | err_parity;
    assign irq_tx  = cfg_txirq_sel ? line_idle : hold_empty;
    assign irq_rx  = rx_full;

    // R10
    txirq_complete_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_txirq_sel && irq_tx) |-> txd);
endmodule

// File: tb/sim_sercom_xcvr.sv
`timescale 1ns/1ps
module sim_sercom_xcvr;
    logic       clk = 1'b0, rst = 1'b1;
    logic [1:0] cfg_src = 2'd0, cfg_len = 2'd1, cfg_par = 2'd0;
    logic       cfg_ext = 1'b0, cfg_stop2 = 1'b0, cfg_txirq_sel = 1'b0;
    logic [7:0] cfg_div = 8'd1;
    logic       aux_tick = 1'b0, ext_clk = 1'b0, tx_wr = 1'b0, rx_rd = 1'b0;
    logic [8:0] tx_data = '0;
    logic       loop = 1'b1, drv = 1'b1;
    logic       txd, rxd, rx_full, err_overrun, err_frame, err_parity, err_sum, irq_tx, irq_rx;
    logic [8:0] rx_data;
    int checks = 0, fails = 0;
    int aux_cnt = 0, ext_cnt = 0;

    assign rxd = loop ? txd : drv;

    sercom_xcvr u0 (
        .clk(clk), .rst(rst), .cfg_src(cfg_src), .cfg_ext(cfg_ext), .cfg_div(cfg_div),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop2(cfg_stop2),
        .cfg_txirq_sel(cfg_txirq_sel), .aux_tick(aux_tick), .ext_clk(ext_clk),
        .tx_wr(tx_wr), .tx_data(tx_data), .txd(txd), .rxd(rxd), .rx_rd(rx_rd),
        .rx_data(rx_data), .rx_full(rx_full), .err_overrun(err_overrun),
        .err_frame(err_frame), .err_parity(err_parity), .err_sum(err_sum),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    always #2.5 clk = ~clk;

    // auxiliary enable every 3rd cycle, external clock period of 4 cycles
    always @(negedge clk) begin
        aux_cnt  = (aux_cnt == 2) ? 0 : aux_cnt + 1;
        aux_tick = (aux_cnt == 2);
        ext_cnt  = ext_cnt + 1;
        if (ext_cnt % 2 == 0) ext_clk = ~ext_clk;
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // per-clock model comparison of the combined flags
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9", "err_sum", err_sum, err_overrun | err_frame | err_parity);
            chk("R5", "irq_rx", irq_rx, rx_full);
        end
    end

    function automatic int frame_bits(logic [8:0] d, int nb, int par, bit s2, output logic [15:0] fb);
        int n = 0;
        logic p = (par == 2);
        fb = '1;
        fb[n++] = 1'b0;
        for (int i = 0; i < nb; i++) begin
            fb[n++] = d[i];
            p = p ^ d[i];
        end
        if (par != 0) fb[n++] = p;
        fb[n++] = 1'b1;
        if (s2) fb[n++] = 1'b1;
        return n;
    endfunction

    task automatic send(logic [8:0] d);
        while (irq_tx !== 1'b1) @(negedge clk);
        tx_wr = 1'b1; tx_data = d;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic check_tx(logic [8:0] d, int nb, int par, bit s2, int bpc, string req);
        logic [15:0] fb;
        int len = frame_bits(d, nb, par, s2, fb);
        while (txd !== 1'b0) @(negedge clk);
        repeat (bpc / 2) @(negedge clk);
        for (int k = 0; k < len; k++) begin
            chk(req, "tx bit", txd, fb[k]);
            if (k < len - 1) repeat (bpc) @(negedge clk);
        end
    endtask

    task automatic expect_rx(logic [8:0] d, bit fe, bit pe, string req);
        while (rx_full !== 1'b1) @(negedge clk);
        chk(req, "rx_data", rx_data, d);
        chk(req, "err_frame", err_frame, fe);
        chk(req, "err_parity", err_parity, pe);
        chk("R9", "err_sum", err_sum, fe | pe);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk("R5", "rx_full after read", rx_full, 1'b0);
    endtask

    task automatic drive_frame(logic [8:0] d, int nb, int par, bit bad_par, bit bad_stop, int bpc);
        logic [15:0] fb;
        int len = frame_bits(d, nb, par, 1'b0, fb);
        if (bad_par) fb[1+nb] = ~fb[1+nb];
        if (bad_stop) fb[len-1] = 1'b0;
        for (int k = 0; k < len; k++) begin
            drv = fb[k];
            repeat (bpc) @(negedge clk);
        end
        drv = 1'b1;
    endtask

    task automatic measure(logic [1:0] src, bit ext, logic [7:0] dv, int exp);
        int cnt = 0;
        cfg_txirq_sel = 1'b1;
        while (irq_tx !== 1'b1) @(negedge clk);
        cfg_src = src; cfg_ext = ext; cfg_div = dv;
        send(9'h000);
        while (txd !== 1'b0) @(negedge clk);
        while (txd === 1'b0) begin
            cnt++;
            @(negedge clk);
        end
        chk("R4", "low time of zero character", cnt, exp);
        while (irq_tx !== 1'b1) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "txd", txd, 1'b1);
        chk("R1", "rx_full", rx_full, 1'b0);
        chk("R1", "irq_rx", irq_rx, 1'b0);
        chk("R1", "errors", {err_overrun, err_frame, err_parity, err_sum}, 4'b0);
        chk("R1", "irq_tx", irq_tx, 1'b1);

        // R2 8 data bits, no parity, one stop
        send(9'h0A5);
        check_tx(9'h0A5, 8, 0, 1'b0, 32, "R2");
        expect_rx(9'h0A5, 1'b0, 1'b0, "R5");

        // R3 7 data bits even parity, upper bits masked
        cfg_len = 2'd0; cfg_par = 2'd1;
        send(9'h1DB);
        check_tx(9'h1DB, 7, 1, 1'b0, 32, "R3");
        expect_rx(9'h05B, 1'b0, 1'b0, "R3");

        // R2 9 data bits odd parity two stops
        cfg_len = 2'd2; cfg_par = 2'd2; cfg_stop2 = 1'b1;
        send(9'h1C3);
        check_tx(9'h1C3, 9, 2, 1'b1, 32, "R2");
        expect_rx(9'h1C3, 1'b0, 1'b0, "R3");

        // R3 8 data bits even parity two stops
        cfg_len = 2'd1; cfg_par = 2'd1;
        send(9'h03C);
        check_tx(9'h03C, 8, 1, 1'b1, 32, "R3");
        expect_rx(9'h03C, 1'b0, 1'b0, "R3");

        // R10 transmit interrupt meaning
        cfg_par = 2'd0; cfg_stop2 = 1'b0;
        repeat (64) @(negedge clk);
        send(9'h011);
        repeat (96) @(negedge clk);
        chk("R10", "irq_tx buffer-empty mid frame", irq_tx, 1'b1);
        expect_rx(9'h011, 1'b0, 1'b0, "R10");
        repeat (32) @(negedge clk);
        cfg_txirq_sel = 1'b1;
        @(negedge clk);
        chk("R10", "irq_tx complete when idle", irq_tx, 1'b1);
        send(9'h022);
        repeat (96) @(negedge clk);
        chk("R10", "irq_tx complete mid frame", irq_tx, 1'b0);
        expect_rx(9'h022, 1'b0, 1'b0, "R10");
        repeat (32) @(negedge clk);
        chk("R10", "irq_tx complete after frame", irq_tx, 1'b1);

        // R11 write into a full holding register
        cfg_txirq_sel = 1'b0;
        send(9'h031);
        send(9'h032);
        tx_wr = 1'b1; tx_data = 9'h033;
        @(negedge clk);
        tx_wr = 1'b0;
        expect_rx(9'h031, 1'b0, 1'b0, "R11");
        expect_rx(9'h032, 1'b0, 1'b0, "R11");
        repeat (32 * 12) @(negedge clk);
        chk("R11", "no third character", rx_full, 1'b0);

        // R6 parity error
        loop = 1'b0; drv = 1'b1; cfg_par = 2'd1;
        repeat (64) @(negedge clk);
        drive_frame(9'h05A, 8, 1, 1'b1, 1'b0, 32);
        expect_rx(9'h05A, 1'b0, 1'b1, "R6");

        // R7 framing error, then cleared by a good character
        cfg_par = 2'd0;
        drive_frame(9'h00F, 8, 0, 1'b0, 1'b1, 32);
        expect_rx(9'h00F, 1'b1, 1'b0, "R7");
        repeat (64) @(negedge clk);
        drive_frame(9'h070, 8, 0, 1'b0, 1'b0, 32);
        expect_rx(9'h070, 1'b0, 1'b0, "R7");

        // R8 overrun
        drive_frame(9'h041, 8, 0, 1'b0, 1'b0, 32);
        drive_frame(9'h042, 8, 0, 1'b0, 1'b0, 32);
        repeat (4) @(negedge clk);
        chk("R8", "rx_full", rx_full, 1'b1);
        chk("R8", "rx_data kept", rx_data, 9'h041);
        chk("R8", "err_overrun", err_overrun, 1'b1);
        chk("R9", "err_sum on overrun", err_sum, 1'b1);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        chk("R8", "rx_full cleared", rx_full, 1'b0);
        chk("R8", "err_overrun cleared", err_overrun, 1'b0);

        // R12 short low glitch
        drv = 1'b0;
        repeat (3) @(negedge clk);
        drv = 1'b1;
        repeat (32 * 12) @(negedge clk);
        chk("R12", "glitch ignored", rx_full, 1'b0);
        drive_frame(9'h066, 8, 0, 1'b0, 1'b0, 32);
        expect_rx(9'h066, 1'b0, 1'b0, "R12");

        // R4 clock sources: zero character is 9 low bits
        measure(2'd0, 1'b0, 8'd3, 9 * 16 * 4);
        measure(2'd1, 1'b0, 8'd0, 9 * 16 * 8);
        measure(2'd2, 1'b0, 8'd0, 9 * 16 * 32);
        measure(2'd3, 1'b0, 8'd0, 9 * 16 * 3);
        measure(2'd0, 1'b1, 8'd0, 9 * 16 * 4);

        summary();
        $finish;
    end
endmodule